// File: doc/BRIEF.md
# Register-Mapped GPIO Bank with Line Interrupts

This block gives software a bank of general-purpose I/O lines behind a simple word-wide register bus. Output levels are changed only through two write-one strobe registers, one that raises bits and one that lowers them, so no read-modify-write is ever needed. Each line's drive direction comes from a direction register whose sense is fixed by a build parameter. The synchronised pin levels can be read back at any time.

Every line can also raise an interrupt. A type bit and a polarity bit per line select one of four sensing modes, decoded as `{type, polarity}`: `SENSE_FALL` (00), `SENSE_RISE` (01), `SENSE_LOW` (10) and `SENSE_HIGH` (11). Each line's detector moves between idle and pending. Idle goes to pending on a detected condition while the line is enabled. Pending goes back to idle on a write-one clear for edge lines, on the active level going away for level lines, or on the line being disabled. The single interrupt request is the OR over all lines of pending, enable and mask. Software can catch both edges by flipping the polarity bit after each event, and the hardware takes the new polarity into account from the next sampled cycle.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every line is an input (`pin_oe` all 0), `pin_out` is 0, and the enable, type, polarity, mask and pending registers read 0 with `irq` low.
- R2: Writing the set register (offset 0x0C) drives high each output whose data bit is 1 and leaves the others unchanged. Reading offset 0x0C or 0x10 returns the output latch.
- R3: Writing the clear register (offset 0x10) drives low each output whose data bit is 1 and leaves the others unchanged.
- R4: The direction register (offset 0x00) resets so that all lines are inputs. With `OE_INVERT`=0, a 1 makes the line an output (`pin_oe` bit = 1). With `OE_INVERT`=1, a 1 makes it an input.
- R5: The input register (offset 0x04) returns the pin levels after a two-flop synchroniser and ignores writes.
- R6: An enabled edge line (type bit 0 at offset 0x18) sets its pending bit (offset 0x20) on a rising pin edge when its polarity bit (offset 0x1C) is 1, and on a falling edge when it is 0. The bit is visible within four clocks of the pin change.
- R7: An enabled level line (type bit 1) has a pending bit that follows the active level: high when polarity is 1, low when it is 0.
- R8: Writing 1 to a pending bit of an edge line clears it, and bits written 0 are unchanged.
- R9: `irq` is high exactly when some line has pending, enable (offset 0x14) and mask (offset 0x24) all 1. Clearing a mask bit hides the line without losing its pending state.
- R10: A line whose enable bit is 0 shows no pending bit and never raises `irq`.
- R11: Register bits at or above `NUM_LINES` read 0 and ignore writes.
- R12: A polarity change takes effect from the next sampled cycle, so flipping polarity after an event lets an edge line catch the opposite edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` after the next edge |
| bus_addr | input | 6 | Byte offset of the register, word-aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_LINES | Raw pin levels (asynchronous) |
| pin_out | output | NUM_LINES | Output latch driven to the pads |
| pin_oe | output | NUM_LINES | Drive enable, 1 = line drives |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is the software both-edge pattern. A line must catch a rising edge, be cleared, have its polarity rewritten to the inverse of the current level, and then catch the falling edge. The pending bit and the clear write must not race. The bench gets there by running exactly that sequence on one line with pin changes spaced well past the synchroniser delay. It also holds a masked line pending while checking that `irq` stays low and the pending bit survives.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int BUS_AW = 6;
    localparam int BUS_DW = 32;

    localparam logic [BUS_AW-1:0] OFS_DIR   = 6'h00;
    localparam logic [BUS_AW-1:0] OFS_PIN   = 6'h04;
    localparam logic [BUS_AW-1:0] OFS_SET   = 6'h0C;
    localparam logic [BUS_AW-1:0] OFS_CLR   = 6'h10;
    localparam logic [BUS_AW-1:0] OFS_IEN   = 6'h14;
    localparam logic [BUS_AW-1:0] OFS_ITYPE = 6'h18;
    localparam logic [BUS_AW-1:0] OFS_IPOL  = 6'h1C;
    localparam logic [BUS_AW-1:0] OFS_IPEND = 6'h20;
    localparam logic [BUS_AW-1:0] OFS_IMASK = 6'h24;

    // encoded as {type, polarity}
    typedef enum logic [1:0] {
        SENSE_FALL = 2'b00,
        SENSE_RISE = 2'b01,
        SENSE_LOW  = 2'b10,
        SENSE_HIGH = 2'b11
    } sense_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            sync_o   <= '0;
        end else begin
            stage1_q <= async_i;
            sync_o   <= stage1_q;
        end
    end
endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp_i,
    input  logic en_i,
    input  logic typ_i,
    input  logic pol_i,
    input  logic clr_i,
    output logic pend_o
);
    logic   prev_q;
    logic   hit;
    sense_e mode;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= smp_i;
    end

    always_comb begin
        mode = sense_e'({typ_i, pol_i});
        unique case (mode)
            SENSE_FALL: hit = prev_q & ~smp_i;
            SENSE_RISE: hit = ~prev_q & smp_i;
            SENSE_LOW:  hit = ~smp_i;
            SENSE_HIGH: hit = smp_i;
            default:    hit = 1'b0;
        endcase
    end

    // idle <-> pending; detection wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_o <= 1'b0;
        else if (!en_i)  pend_o <= 1'b0;
        else if (typ_i)  pend_o <= hit;
        else if (hit)    pend_o <= 1'b1;
        else if (clr_i)  pend_o <= 1'b0;
    end

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !typ_i && (smp_i != prev_q) && (smp_i == pol_i)) |=> pend_o); // R6
    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && typ_i) |=> (pend_o == ($past(smp_i) == $past(pol_i)))); // R7
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !pend_o); // R10
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter bit OE_INVERT = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [5:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] pin_out,
    output logic [NUM_LINES-1:0] pin_oe,
    output logic                 irq
);
    localparam int N   = NUM_LINES;
    localparam int PAD = BUS_DW - N;
    localparam logic [N-1:0] DIR_RST = OE_INVERT ? {N{1'b1}} : {N{1'b0}};

    logic [N-1:0] dir_q, out_q, ien_q, ityp_q, ipol_q, imask_q;
    logic [N-1:0] smp, pend, pend_clr, wd, rd_val;

    assign wd = bus_wdata[N-1:0];

    gpio_sync #(.WIDTH(N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_in),
        .sync_o (smp)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= DIR_RST;
            out_q   <= '0;
            ien_q   <= '0;
            ityp_q  <= '0;
            ipol_q  <= '0;
            imask_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_DIR:   dir_q   <= wd;
                OFS_SET:   out_q   <= out_q | wd;
                OFS_CLR:   out_q   <= out_q & ~wd;
                OFS_IEN:   ien_q   <= wd;
                OFS_ITYPE: ityp_q  <= wd;
                OFS_IPOL:  ipol_q  <= wd;
                OFS_IMASK: imask_q <= wd;
                default:   ;
            endcase
        end
    end

    assign pend_clr = (bus_wr && bus_addr == OFS_IPEND) ? wd : '0;

    for (genvar i = 0; i < N; i++) begin : g_line
        gpio_irq_line u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .smp_i (smp[i]),
            .en_i  (ien_q[i]),
            .typ_i (ityp_q[i]),
            .pol_i (ipol_q[i]),
            .clr_i (pend_clr[i]),
            .pend_o(pend[i])
        );
    end

    assign pin_out = out_q;
    assign pin_oe  = OE_INVERT ? ~dir_q : dir_q;
    assign irq     = |(pend & ien_q & imask_q);

    always_comb begin
        case (bus_addr)
            OFS_DIR:   rd_val = dir_q;
            OFS_PIN:   rd_val = smp;
            OFS_SET:   rd_val = out_q;
            OFS_CLR:   rd_val = out_q;
            OFS_IEN:   rd_val = ien_q;
            OFS_ITYPE: rd_val = ityp_q;
            OFS_IPOL:  rd_val = ipol_q;
            OFS_IPEND: rd_val = pend;
            OFS_IMASK: rd_val = imask_q;
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= {{PAD{1'b0}}, rd_val};
    end

    AST_SET_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_SET) |=> ((pin_out & $past(wd)) == $past(wd))); // R2
    AST_CLR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CLR) |=> ((pin_out & $past(wd)) == '0)); // R3
    AST_MASK_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (imask_q == '0) |-> !irq); // R9
    AST_PIN_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_PIN) |=> (pin_out == $past(pin_out))); // R5
endmodule

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
    import gpio_irq_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [N-1:0] pin_in = '0, pin_out, pin_oe;
    logic irq;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_bank #(.NUM_LINES(N), .OE_INVERT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // {addr, write data, expected readback}
    localparam logic [69:0] VEC [9] = '{
        {OFS_DIR,   32'hFFFF_FFFF, 32'h0000_FFFF},  // R4 R11
        {OFS_SET,   32'h0000_00A5, 32'h0000_00A5},  // R2
        {OFS_CLR,   32'h0000_0021, 32'h0000_0084},  // R3
        {OFS_SET,   32'h8001_0000, 32'h0000_0084},  // R11
        {OFS_IEN,   32'h0000_F0F0, 32'h0000_F0F0},
        {OFS_ITYPE, 32'h1234_5678, 32'h0000_5678},  // R11
        {OFS_IPOL,  32'hFFFF_0001, 32'h0000_0001},
        {OFS_IMASK, 32'h0003_0003, 32'h0000_0003},
        {OFS_PIN,   32'h0000_FFFF, 32'h0000_0000}   // R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wait_clks(3);
        rst_n = 1'b1;
        wait_clks(1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        do_reset();

        for (int i = 0; i < 9; i++) begin
            wr(VEC[i][69:64], VEC[i][63:32]);
            rd(VEC[i][69:64], r);
            check($sformatf("R11 table entry %0d", i), r, VEC[i][31:0]);
        end
        check("R2 R3 pin_out after strobes", {16'h0, pin_out}, 32'h84);
        check("R4 pin_oe normal sense", {16'h0, pin_oe}, 32'hFFFF);

        do_reset();
        check("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
        check("R1 pin_out", {16'h0, pin_out}, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        rd(OFS_IEN, r);   check("R1 enable", r, 0);
        rd(OFS_ITYPE, r); check("R1 type", r, 0);
        rd(OFS_IPOL, r);  check("R1 polarity", r, 0);
        rd(OFS_IMASK, r); check("R1 mask", r, 0);
        rd(OFS_IPEND, r); check("R1 pending", r, 0);
        rd(OFS_DIR, r);   check("R4 direction reset", r, 0);

        pin_in = 16'h5A5A;
        wait_clks(3);
        rd(OFS_PIN, r); check("R5 input pattern", r, 32'h5A5A);
        pin_in = 16'h0002;
        wait_clks(3);

        // line0 rising edge, line1 falling edge
        wr(OFS_IPOL, 32'h0001);
        wr(OFS_IEN, 32'h0003);
        wr(OFS_IMASK, 32'h0003);
        rd(OFS_IPEND, r); check("R6 no edge yet", r, 0);
        pin_in = 16'h0001;
        wait_clks(4);
        rd(OFS_IPEND, r); check("R6 rise and fall pending", r, 32'h3);
        check("R9 irq on", {31'h0, irq}, 1);
        wr(OFS_IMASK, 32'h0000);
        check("R9 masked irq off", {31'h0, irq}, 0);
        rd(OFS_IPEND, r); check("R9 pending kept under mask", r, 32'h3);
        wr(OFS_IMASK, 32'h0003);
        check("R9 unmask irq back", {31'h0, irq}, 1);
        wr(OFS_IPEND, 32'h0002);
        rd(OFS_IPEND, r); check("R8 clear one bit", r, 32'h1);
        wr(OFS_IPEND, 32'h0001);
        rd(OFS_IPEND, r); check("R8 clear other bit", r, 0);
        check("R9 irq off after clear", {31'h0, irq}, 0);

        // line2 level active-low
        wr(OFS_IEN, 32'h0000);
        pin_in = 16'h0004;
        wait_clks(3);
        wr(OFS_ITYPE, 32'h0004);
        wr(OFS_IPOL, 32'h0000);
        wr(OFS_IEN, 32'h0004);
        wr(OFS_IMASK, 32'h0004);
        wait_clks(2);
        rd(OFS_IPEND, r); check("R7 inactive level", r, 0);
        pin_in = 16'h0000;
        wait_clks(4);
        rd(OFS_IPEND, r); check("R7 active level", r, 32'h4);
        check("R9 irq level", {31'h0, irq}, 1);
        pin_in = 16'h0004;
        wait_clks(4);
        rd(OFS_IPEND, r); check("R7 level released", r, 0);

        // line3 disabled edge line
        wr(OFS_ITYPE, 32'h0000);
        wr(OFS_IPOL, 32'h0008);
        wr(OFS_IEN, 32'h0000);
        wr(OFS_IMASK, 32'hFFFF);
        pin_in = 16'h000C;
        wait_clks(4);
        rd(OFS_IPEND, r); check("R10 disabled no pending", r, 0);
        check("R10 disabled no irq", {31'h0, irq}, 0);

        // line4 both-edge emulation
        wr(OFS_IPOL, 32'h0010);
        wr(OFS_IEN, 32'h0010);
        pin_in = 16'h001C;
        wait_clks(4);
        rd(OFS_IPEND, r); check("R12 rise caught", r, 32'h10);
        wr(OFS_IPEND, 32'h0010);
        wr(OFS_IPOL, 32'h0000);
        rd(OFS_IPEND, r); check("R12 cleared before fall", r, 0);
        pin_in = 16'h000C;
        wait_clks(4);
        rd(OFS_IPEND, r); check("R12 fall caught after flip", r, 32'h10);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule